// File: doc/BRIEF.md
# Quad 8-bit DAC serial command front end

This block is the digital side of a four-channel, 8-bit, double-buffered digital-to-analog converter. A host sends 12-bit command words over a three-wire serial port: a serial clock, a data line and an active-low chip select. Every bit is taken on a rising serial clock while chip select is low. When chip select goes high again, the most recent 12 bits are decoded into actions on four input (staging) registers and four DAC registers. The four DAC register values leave the block as one packed bus that feeds the converters.

Two active-low side pins act on the registers at any time. The load pin makes every DAC register follow its input register while it is held low. The clear pin forces every register to zero. The end of the shift chain is driven out as a serial output. The host can use it to read data back, or it can feed the data input of the next device in a chain. A command selects whether this output moves on the rising or the falling serial clock edge.

All pins are sampled in one fast system clock domain. The system clock must run at least four times the serial clock rate. A small state machine tracks the frame. It has three states. In `LNK_IDLE` chip select is high. In `LNK_SHIFT` chip select is low and bits are being taken. `LNK_EXEC` lasts one cycle and issues the decoded command. The transitions are: select-fall (`LNK_IDLE` to `LNK_SHIFT`), select-rise (`LNK_SHIFT` to `LNK_EXEC`), and either done (`LNK_EXEC` to `LNK_IDLE`) or reselect (`LNK_EXEC` to `LNK_SHIFT`, when chip select is already low again).

Top module: `qdac_serial_front`

## Requirements
- R1: A word is 12 bits, sent MSB first: a 2-bit channel address, then a 2-bit control code, then 8 data bits (MSB first). Address 0 is channel A, on `dac_code[7:0]`; 1 is B, on [15:8]; 2 is C, on [23:16]; 3 is D, on [31:24]. Only the last 12 bits before chip select rises are decoded, so the leading bits of a longer frame are discarded.
- R2: While chip select is high, serial clock edges do not shift data, and the serial output keeps its value.
- R3: Control code 01 writes the data byte into the addressed input register. All DAC registers stay unchanged.
- R4: Control code 11 writes the data byte into both the addressed input register and the addressed DAC register.
- R5: Control code 00 with address bit 0 cleared writes the data byte into all four input registers and all four DAC registers. Address bit 1 is ignored.
- R6: Control code 00 with address bit 0 set is a no-operation. No register changes. In a chain, this lets a device pass its word along while the other devices are updated.
- R7: Control code 10 with address bit 1 cleared copies every input register into its DAC register.
- R8: Control code 10 with address bit 1 set also copies every input register into its DAC register. It then latches the output phase: address bit 0 set selects rising-edge output, and address bit 0 cleared selects falling-edge output. No other command changes the phase.
- R9: In rising phase, the serial output changes after a rising serial clock edge and shows the bit taken 12 rising edges earlier. In falling phase, it changes after the falling edge that follows, which gives a lag of 12.5 clocks.
- R10: While the load pin is low, every DAC register follows its input register, including input writes made by commands during that time.
- R11: While the clear pin is low, all input and DAC registers are zero. This overrides any command issued at the same time.
- R12: After reset, all registers and the shifter are zero, the serial output is 0, and the output phase is rising.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in, taken on the rising serial clock |
| cs_n | input | 1 | Active-low chip select; its rising edge runs the command |
| ldac_n | input | 1 | Active-low load; DAC registers follow input registers while low |
| clr_n | input | 1 | Active-low clear of all input and DAC registers |
| dout | output | 1 | End of the shift chain, for read-back or chaining |
| dac_code | output | NCH*DW | Packed DAC register values, channel A in the lowest byte |

## Verification
Two cases can land on the same system clock cycle. In the first, a command runs while the load pin is low. In the second, a command runs while the clear pin is low. The bench provokes the first by holding load low across a frame that writes only an input register. The DAC output of that channel must then take the new byte. It provokes the second by holding clear low across a load-both frame. Every DAC output must stay zero, both during the frame and after clear is released. The behavioural model judges both cases from its priority order: the command first, then the load pin's transparency, then the clear pin.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // Link state machine states.
    typedef enum logic [1:0] {
        LNK_IDLE,
        LNK_SHIFT,
        LNK_EXEC
    } lnk_state_t;

    // Decoded register operations.
    typedef enum logic [2:0] {
        OP_NOP,
        OP_LOAD_IN,
        OP_LOAD_BOTH,
        OP_LOAD_ALL,
        OP_XFER,
        OP_XFER_RISE,
        OP_XFER_FALL
    } op_t;

    // hi_bit / lo_bit are the upper and lower address bits.
    function automatic op_t decode_op(input logic hi_bit, input logic lo_bit,
                                      input logic [1:0] ctl);
        op_t res;
        unique case (ctl)
            2'b01: res = OP_LOAD_IN;
            2'b11: res = OP_LOAD_BOTH;
            2'b00: res = lo_bit ? OP_NOP : OP_LOAD_ALL;
            2'b10: res = !hi_bit ? OP_XFER : (lo_bit ? OP_XFER_RISE : OP_XFER_FALL);
        endcase
        return res;
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int              WIDTH  = 1,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/qdac_link.sv
module qdac_link
    import qdac_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 8,
    localparam int WORD_W = AW + 2 + DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          din_s,
    input  logic          cs_n_s,
    output logic          dout,
    output logic          phase_rise,
    output logic          exec,
    output op_t           op,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    lnk_state_t        state, state_nx;
    logic [WORD_W-1:0] sr;
    logic              sclk_d;
    logic              sclk_up, sclk_dn;
    logic [1:0]        ctl;

    assign sclk_up = sclk_s & ~sclk_d;
    assign sclk_dn = ~sclk_s & sclk_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LNK_IDLE;
        else        state <= state_nx;
    end

    // Next state.
    always_comb begin
        state_nx = state;
        unique case (state)
            LNK_IDLE:  if (!cs_n_s) state_nx = LNK_SHIFT;   // select-fall
            LNK_SHIFT: if (cs_n_s)  state_nx = LNK_EXEC;    // select-rise
            LNK_EXEC:  state_nx = cs_n_s ? LNK_IDLE          // done
                                         : LNK_SHIFT;        // reselect
            default:   state_nx = LNK_IDLE;
        endcase
    end

    // Word fields and the command strobe.
    assign addr = sr[WORD_W-1 -: AW];
    assign ctl  = sr[DW+1 -: 2];
    assign data = sr[DW-1:0];
    assign op   = decode_op(addr[AW-1], addr[0], ctl);
    assign exec = (state == LNK_EXEC);

    // Outputs: shifter, serial output and phase latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d     <= 1'b0;
            sr         <= '0;
            dout       <= 1'b0;
            phase_rise <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            if (sclk_up && !cs_n_s) begin
                sr <= {sr[WORD_W-2:0], din_s};
                if (phase_rise) dout <= sr[WORD_W-2];
            end
            if (sclk_dn && !cs_n_s && !phase_rise) dout <= sr[WORD_W-1];
            if (exec) begin
                if (op == OP_XFER_RISE) phase_rise <= 1'b1;
                if (op == OP_XFER_FALL) phase_rise <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    localparam int AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  op_t               op,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     data,
    input  logic              ldac_n_s,
    input  logic              clr_n_s,
    output logic [NCH*DW-1:0] inp_flat,
    output logic [NCH*DW-1:0] dac_flat
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [DW-1:0] inp_q, dac_q, inp_nx, dac_nx;
        logic          hit;

        assign hit = (addr == AW'(ch));

        always_comb begin
            inp_nx = inp_q;
            dac_nx = dac_q;
            if (exec) begin
                unique case (op)
                    OP_LOAD_IN:   if (hit) inp_nx = data;
                    OP_LOAD_BOTH: if (hit) begin
                        inp_nx = data;
                        dac_nx = data;
                    end
                    OP_LOAD_ALL: begin
                        inp_nx = data;
                        dac_nx = data;
                    end
                    OP_XFER, OP_XFER_RISE, OP_XFER_FALL: dac_nx = inp_q;
                    default: ;
                endcase
            end
            if (!ldac_n_s) dac_nx = inp_nx;
            if (!clr_n_s) begin
                inp_nx = '0;
                dac_nx = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                inp_q <= '0;
                dac_q <= '0;
            end else begin
                inp_q <= inp_nx;
                dac_q <= dac_nx;
            end
        end

        assign inp_flat[ch*DW +: DW] = inp_q;
        assign dac_flat[ch*DW +: DW] = dac_q;
    end

endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
    import qdac_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              cs_n,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic              dout,
    output logic [NCH*DW-1:0] dac_code
);

    localparam int AW     = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int NPIN   = 5;

    logic [NPIN-1:0]   raw_v, syn_v;
    logic              cs_n_s, sclk_s, din_s, ldac_n_s, clr_n_s;
    logic              exec, phase_rise;
    op_t               op;
    logic [AW-1:0]     addr;
    logic [DW-1:0]     data;
    logic [NCH*DW-1:0] inp_flat, dac_flat;

    assign raw_v = {cs_n, sclk, din, ldac_n, clr_n};

    // Idle levels: select high, clock low, data low, load high, clear high.
    qdac_sync #(
        .WIDTH (NPIN),
        .STAGES(SYNC_STAGES),
        .INIT  (5'b10011)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_v),
        .q    (syn_v)
    );

    assign cs_n_s   = syn_v[4];
    assign sclk_s   = syn_v[3];
    assign din_s    = syn_v[2];
    assign ldac_n_s = syn_v[1];
    assign clr_n_s  = syn_v[0];

    qdac_link #(
        .AW(AW),
        .DW(DW)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .din_s     (din_s),
        .cs_n_s    (cs_n_s),
        .dout      (dout),
        .phase_rise(phase_rise),
        .exec      (exec),
        .op        (op),
        .addr      (addr),
        .data      (data)
    );

    qdac_regbank #(
        .NCH(NCH),
        .DW (DW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec    (exec),
        .op      (op),
        .addr    (addr),
        .data    (data),
        .ldac_n_s(ldac_n_s),
        .clr_n_s (clr_n_s),
        .inp_flat(inp_flat),
        .dac_flat(dac_flat)
    );

    assign dac_code = dac_flat;

endmodule

// File: rtl/qdac_front_checker.sv
module qdac_front_checker
    import qdac_pkg::*;
#(
    parameter int FLAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_s,
    input logic              ldac_n_s,
    input logic              clr_n_s,
    input logic              dout,
    input logic              exec,
    input op_t               op,
    input logic              phase_rise,
    input logic [FLAT_W-1:0] inp_flat,
    input logic [FLAT_W-1:0] dac_flat
);

    assert_exec_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> !exec);

    assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(dout));

    assert_load_in_keeps_dac_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_LOAD_IN && ldac_n_s && clr_n_s) |=> $stable(dac_flat));

    assert_nop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_NOP && ldac_n_s && clr_n_s)
            |=> ($stable(inp_flat) && $stable(dac_flat)));

    assert_phase_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec && (op == OP_XFER_RISE || op == OP_XFER_FALL)) |=> $stable(phase_rise));

    assert_ldac_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldac_n_s && clr_n_s) |=> (dac_flat == inp_flat));

    assert_clr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_s |=> (inp_flat == '0 && dac_flat == '0));

endmodule

bind qdac_serial_front qdac_front_checker #(
    .FLAT_W(NCH*DW)
) u_front_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .ldac_n_s  (ldac_n_s),
    .clr_n_s   (clr_n_s),
    .dout      (dout),
    .exec      (exec),
    .op        (op),
    .phase_rise(phase_rise),
    .inp_flat  (inp_flat),
    .dac_flat  (dac_flat)
);

// File: tb/qdac_serial_front_bench.sv
module qdac_serial_front_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;     // system clocks per serial half period
    localparam int NCH        = 4;
    localparam int DW         = 8;
    localparam int WW         = 12;
    localparam int LIMIT      = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, din = 1'b0, cs_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1;
    logic dout_near, dout_far;
    logic [NCH*DW-1:0] code_near, code_far;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    cmp_on = 0;
    string cur_req = "R12";

    // Behavioural model, index 0 = near device, 1 = far device.
    logic [DW-1:0] m_inp [2][NCH];
    logic [DW-1:0] m_dac [2][NCH];
    bit            m_rise [2];
    logic [WW-1:0] m_sr [2];
    logic          m_dout [2];
    bit            m_ldac_low = 0;
    bit            m_clr_low = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_serial_front u_qdac_serial_front (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .cs_n(cs_n),
        .ldac_n(ldac_n), .clr_n(clr_n), .dout(dout_near), .dac_code(code_near)
    );

    qdac_serial_front u_qdac_serial_front_far (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(dout_near), .cs_n(cs_n),
        .ldac_n(ldac_n), .clr_n(clr_n), .dout(dout_far), .dac_code(code_far)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] got(input int d, input int ch);
        return (d == 0) ? code_near[ch*DW +: DW] : code_far[ch*DW +: DW];
    endfunction

    task automatic compare_all();
        for (int d = 0; d < 2; d++)
            for (int ch = 0; ch < NCH; ch++)
                check(cur_req, $sformatf("dev%0d ch%0d", d, ch), 32'(got(d, ch)), 32'(m_dac[d][ch]));
        check("R9", "dout dev0", 32'(dout_near), 32'(m_dout[0]));
        check("R9", "dout dev1", 32'(dout_far), 32'(m_dout[1]));
    endtask

    // Comparison on every clock while the pins are quiet.
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int d = 0; d < 2; d++)
                for (int ch = 0; ch < NCH; ch++)
                    check(cur_req, "clocked compare", 32'(got(d, ch)), 32'(m_dac[d][ch]));
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected<%0d", cycles, LIMIT);
            summary();
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic void apply(input int d);
        logic [WW-1:0] w;
        logic [1:0] c;
        logic [DW-1:0] v;
        int ch;
        w  = m_sr[d];
        c  = w[9:8];
        v  = w[7:0];
        ch = int'(w[11:10]);
        if (c == 2'b01) m_inp[d][ch] = v;
        else if (c == 2'b11) begin
            m_inp[d][ch] = v;
            m_dac[d][ch] = v;
        end else if (c == 2'b00 && !w[10]) begin
            for (int k = 0; k < NCH; k++) begin
                m_inp[d][k] = v;
                m_dac[d][k] = v;
            end
        end else if (c == 2'b10) begin
            for (int k = 0; k < NCH; k++) m_dac[d][k] = m_inp[d][k];
            if (w[11]) m_rise[d] = w[10];
        end
        if (m_ldac_low) for (int k = 0; k < NCH; k++) m_dac[d][k] = m_inp[d][k];
        if (m_clr_low) for (int k = 0; k < NCH; k++) begin
            m_inp[d][k] = '0;
            m_dac[d][k] = '0;
        end
    endfunction

    task automatic rise_edge();
        logic pass_bit;
        pass_bit = m_dout[0];
        sclk = 1'b1;
        m_sr[1] = {m_sr[1][WW-2:0], pass_bit};
        m_sr[0] = {m_sr[0][WW-2:0], din};
        for (int d = 0; d < 2; d++) if (m_rise[d]) m_dout[d] = m_sr[d][WW-1];
        wait_clk(HALF);
        check("R9", "dout after rise dev0", 32'(dout_near), 32'(m_dout[0]));
        check("R9", "dout after rise dev1", 32'(dout_far), 32'(m_dout[1]));
    endtask

    task automatic fall_edge();
        sclk = 1'b0;
        for (int d = 0; d < 2; d++) if (!m_rise[d]) m_dout[d] = m_sr[d][WW-1];
        wait_clk(HALF);
        check("R9", "dout after fall dev0", 32'(dout_near), 32'(m_dout[0]));
        check("R9", "dout after fall dev1", 32'(dout_far), 32'(m_dout[1]));
    endtask

    task automatic send(input logic [63:0] bits, input int n);
        cmp_on = 0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            din = bits[i];
            wait_clk(HALF);
            rise_edge();
            fall_edge();
        end
        cs_n = 1'b1;
        din = 1'b0;
        apply(0);
        apply(1);
        wait_clk(HALF);
        compare_all();
        cmp_on = 1;
        wait_clk(4);
    endtask

    function automatic logic [WW-1:0] word(input logic [1:0] a, input logic [1:0] c,
                                           input logic [DW-1:0] v);
        return {a, c, v};
    endfunction

    // Chain frame: the far device's word goes first.
    task automatic send2(input logic [WW-1:0] far_w, input logic [WW-1:0] near_w);
        send({40'h0, far_w, near_w}, 2 * WW);
    endtask

    task automatic set_pins(input logic ld, input logic cl);
        cmp_on = 0;
        ldac_n = ld;
        clr_n = cl;
        m_ldac_low = !ld;
        m_clr_low = !cl;
        for (int d = 0; d < 2; d++) begin
            if (m_ldac_low) for (int k = 0; k < NCH; k++) m_dac[d][k] = m_inp[d][k];
            if (m_clr_low) for (int k = 0; k < NCH; k++) begin
                m_inp[d][k] = '0;
                m_dac[d][k] = '0;
            end
        end
        wait_clk(HALF);
        compare_all();
        cmp_on = 1;
    endtask

    localparam logic [WW-1:0] NOPW = 12'b01_00_0000_0000;

    initial begin
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < NCH; k++) begin
                m_inp[d][k] = '0;
                m_dac[d][k] = '0;
            end
            m_rise[d] = 1;
            m_sr[d] = '0;
            m_dout[d] = 1'b0;
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R12: reset state.
        cur_req = "R12";
        compare_all();
        check("R12", "dout near after reset", 32'(dout_near), 32'h0);

        // R3: four input-only loads on the near device, far device gets NOP.
        cur_req = "R3";
        send2(NOPW, word(2'd0, 2'b01, 8'h11));
        send2(NOPW, word(2'd1, 2'b01, 8'h22));
        send2(NOPW, word(2'd2, 2'b01, 8'h33));
        send2(NOPW, word(2'd3, 2'b01, 8'h44));
        check("R3", "dac A untouched", 32'(got(0, 0)), 32'h0);

        // R7: software transfer (address bit 1 clear), fifth command.
        cur_req = "R7";
        send2(NOPW, word(2'd0, 2'b10, 8'h00));
        check("R7", "dac D after transfer", 32'(got(0, 3)), 32'h44);

        // R4 and R6: load both on the far device only, near gets NOP.
        cur_req = "R4";
        send2(word(2'd2, 2'b11, 8'hC7), NOPW);
        check("R4", "far dac C", 32'(got(1, 2)), 32'hC7);
        cur_req = "R6";
        check("R6", "near dac C kept", 32'(got(0, 2)), 32'h33);

        // R5: load-all with address bit 1 set (ignored).
        cur_req = "R5";
        send2(word(2'd2, 2'b00, 8'h5A), word(2'd0, 2'b00, 8'hA5));
        check("R5", "near dac B", 32'(got(0, 1)), 32'hA5);

        // R1: 28-bit frame, leading nibble falls out of the chain.
        cur_req = "R1";
        send({36'h0, 4'hF, word(2'd3, 2'b11, 8'h9C), word(2'd1, 2'b11, 8'h3E)}, 28);
        check("R1", "near dac B", 32'(got(0, 1)), 32'h3E);

        // R2: serial clock with select high changes nothing.
        cur_req = "R2";
        din = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            wait_clk(HALF);
        end
        din = 1'b0;
        check("R2", "dout near held", 32'(dout_near), 32'(m_dout[0]));
        check("R2", "dout far held", 32'(dout_far), 32'(m_dout[1]));

        // R8: falling phase on both, then a plain transfer keeps it.
        cur_req = "R8";
        send2(word(2'd2, 2'b10, 8'h00), word(2'd2, 2'b10, 8'h00));
        send2(word(2'd1, 2'b01, 8'h6B), word(2'd3, 2'b01, 8'hD2));
        send2(word(2'd0, 2'b10, 8'h00), word(2'd0, 2'b10, 8'h00));
        check("R8", "near dac D", 32'(got(0, 3)), 32'hD2);
        send2(word(2'd3, 2'b10, 8'h00), NOPW);
        send2(word(2'd0, 2'b11, 8'h81), word(2'd2, 2'b11, 8'h18));

        // R10: load pin low, input-only write shows at the DAC.
        cur_req = "R10";
        send2(NOPW, word(2'd1, 2'b01, 8'hE4));
        set_pins(1'b0, 1'b1);
        check("R10", "near dac B on load low", 32'(got(0, 1)), 32'hE4);
        send2(word(2'd3, 2'b01, 8'h77), word(2'd0, 2'b01, 8'h0F));
        check("R10", "near dac A follows", 32'(got(0, 0)), 32'h0F);
        set_pins(1'b1, 1'b1);

        // R11: clear, and a load-both frame during clear.
        cur_req = "R11";
        set_pins(1'b1, 1'b0);
        send2(word(2'd1, 2'b11, 8'hFF), word(2'd2, 2'b11, 8'hFF));
        check("R11", "near dac C under clear", 32'(got(0, 2)), 32'h0);
        set_pins(1'b1, 1'b1);
        send2(NOPW, word(2'd0, 2'b10, 8'h00));
        check("R11", "near dac A after clear", 32'(got(0, 0)), 32'h0);

        cmp_on = 0;
        summary();
        $finish;
    end

endmodule